// File: doc/BRIEF.md
# Wide-Bus Information Unit CRC Unit

This block produces and verifies the 32-bit CRC that closes every packetized information unit moving over a 16-bit double-transition data bus. Data arrives one 16-bit bus word per strobe. The block treats each word as two bytes: the low half holds the earlier byte and the high half holds the later one. Within each byte the bits enter the CRC least-significant bit first. The polynomial is 104C11DB7h and the register starts at all ones. The result is complemented and leaves the block as two bus words, the low half of the result first.

A segment ends on the word flagged as the last word of the unit, or when a programmed byte interval has been reached. At the end of a segment the block does one of two things, selected per unit. In generate mode it drives the two CRC words onto its output on the next two cycles. In check mode it takes the next two strobed words as the received CRC, compares them with its own result, and reports a pass or a fail pulse. After every CRC, inserted or final, the register returns to all ones.

Top module: `iucrc_unit`

## Requirements
- R1: After synchronous reset, crc_valid, crc_error and crc_ok are all low and no unit is open.
- R2: Word bits 7:0 are the earlier byte and bits 15:8 the later byte. The CRC is the reflected form of polynomial 104C11DB7h, preset to FFFFFFFFh, taken over bytes least-significant bit first and complemented at the end. For 32 bytes of 00h it yields words 55ADh then 190Ah. For 32 bytes of FFh it yields AB0Bh then FF6Ch. For bytes 00h to 1Fh in order it yields 7E8Ah then 9126h.
- R3: In generate mode, crc_valid is high for exactly two cycles, starting the cycle after the edge that accepts the segment's final word. The first cycle carries result bits 15:0 and the second carries bits 31:16.
- R4: With a non-zero interval of N bytes, sampled when the unit opens, a CRC follows every N data bytes. The next segment's CRC covers only the words after the previous CRC.
- R5: With an interval of zero, the only CRC of a unit follows the word that is strobed with iu_last.
- R6: In check mode, the two words strobed after a segment end are compared with the computed CRC words. One cycle after the second of them is accepted, crc_ok pulses if both match and crc_error pulses if either differs.
- R7: In generate mode, words strobed while the two CRC words are being driven are ignored and do not enter the next segment's CRC.
- R8: An iu_start that arrives while data is being accepted resets the CRC register and the byte count. The word strobed with it is the first word of the new unit.
- R9: After a unit's final CRC, words strobed without iu_start are ignored: no CRC follows them, even when they are flagged iu_last.
- R10: crc_error and crc_ok each last one cycle. At most one of crc_valid, crc_error and crc_ok is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| check_mode | input | 1 | Sampled with iu_start: 1 checks the received CRC, 0 generates it |
| iu_start | input | 1 | Opens a unit and presets the CRC |
| crc_interval | input | 16 | Bytes between inserted CRCs, 0 for one CRC at the end; sampled with iu_start |
| word_valid | input | 1 | Strobe for word_in |
| word_in | input | 16 | Bus word, earlier byte in bits 7:0 |
| iu_last | input | 1 | Marks the unit's final data word |
| crc_valid | output | 1 | crc_word carries a generated CRC word |
| crc_word | output | 16 | Generated CRC word, complemented |
| crc_error | output | 1 | One-cycle pulse: received CRC mismatch |
| crc_ok | output | 1 | One-cycle pulse: received CRC match |

## Verification
The bench feeds the three published data patterns. A fault in byte order, bit reflection, the preset or the final complement shows up there as wrong CRC words. It programs an 8-byte interval and checks that the second CRC covers only its own four words, which catches a register that is not re-preset or a counter that is not cleared. It also feeds words while the CRC is being emitted, restarts a unit mid-segment, and strobes words after a unit has closed. A design that absorbed any of those words would produce the wrong CRC or a spurious one. In check mode a correct CRC and a CRC with one flipped bit must raise opposite pulses.

// File: rtl/iucrc_pkg.sv
package iucrc_pkg;
    localparam int WORD_W = 16;
    localparam int CRC_W  = 32;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_PRESET    = '1;

    typedef enum logic [1:0] {
        PH_DATA   = 2'd0,
        PH_CRC_LO = 2'd1,
        PH_CRC_HI = 2'd2
    } phase_t;

    // Folds one bus word into the reflected CRC, bit 0 (earliest) first.
    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                   input logic [WORD_W-1:0] w);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < WORD_W; i++) begin
            if (r[0] ^ w[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/iucrc_engine.sv
module iucrc_engine
    import iucrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              preset,
    input  logic              step,
    input  logic [WORD_W-1:0] word,
    output logic [CRC_W-1:0]  crc_q
);
    logic [CRC_W-1:0] base;

    always_comb base = preset ? CRC_PRESET : crc_q;

    always_ff @(posedge clk) begin
        if (rst)         crc_q <= CRC_PRESET;
        else if (step)   crc_q <= crc_fold(base, word);
        else if (preset) crc_q <= CRC_PRESET;
    end
endmodule

// File: rtl/iucrc_seg_count.sv
module iucrc_seg_count #(
    parameter int IVL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic [IVL_W-1:0] interval,
    output logic             seg_hit
);
    localparam logic [IVL_W:0] BYTES_PER_WORD = 2;

    logic [IVL_W:0] count_q;
    logic [IVL_W:0] base;

    always_comb begin
        base    = clear ? '0 : count_q;
        seg_hit = (interval != '0) && ((base + BYTES_PER_WORD) >= {1'b0, interval});
    end

    always_ff @(posedge clk) begin
        if (rst)       count_q <= '0;
        else if (step) count_q <= base + BYTES_PER_WORD;
        else if (clear) count_q <= '0;
    end
endmodule

// File: rtl/iucrc_unit.sv
module iucrc_unit
    import iucrc_pkg::*;
#(
    parameter int IVL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              check_mode,
    input  logic              iu_start,
    input  logic [IVL_W-1:0]  crc_interval,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic              iu_last,
    output logic              crc_valid,
    output logic [WORD_W-1:0] crc_word,
    output logic              crc_error,
    output logic              crc_ok
);
    localparam int HALF = CRC_W / 2;

    phase_t            phase_q;
    logic              active_q, check_q, final_q, miss_lo_q;
    logic [IVL_W-1:0]  ivl_q, ivl_use;
    logic [CRC_W-1:0]  crc_q, crc_out;
    logic              start_ok, take, seg_hit, seg_end;
    logic              adv, hi_done, preset;

    always_comb begin
        start_ok = iu_start && (phase_q == PH_DATA);
        take     = word_valid && (start_ok || (active_q && phase_q == PH_DATA));
        ivl_use  = start_ok ? crc_interval : ivl_q;
        seg_end  = take && (iu_last || seg_hit);
        adv      = check_q ? word_valid : 1'b1;
        hi_done  = (phase_q == PH_CRC_HI) && adv;
        preset   = start_ok || hi_done;
        crc_out  = ~crc_q;
        crc_valid = !check_q && (phase_q != PH_DATA);
        crc_word  = (phase_q == PH_CRC_HI) ? crc_out[CRC_W-1:HALF] : crc_out[HALF-1:0];
    end

    iucrc_engine u_engine (
        .clk    (clk),
        .rst    (rst),
        .preset (preset),
        .step   (take),
        .word   (word_in),
        .crc_q  (crc_q)
    );

    iucrc_seg_count #(.IVL_W(IVL_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .clear    (preset),
        .step     (take),
        .interval (ivl_use),
        .seg_hit  (seg_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_DATA;
            active_q  <= 1'b0;
            check_q   <= 1'b0;
            final_q   <= 1'b0;
            miss_lo_q <= 1'b0;
            ivl_q     <= '0;
            crc_error <= 1'b0;
            crc_ok    <= 1'b0;
        end else begin
            crc_error <= 1'b0;
            crc_ok    <= 1'b0;
            if (start_ok) begin
                active_q <= 1'b1;
                check_q  <= check_mode;
                ivl_q    <= crc_interval;
            end
            case (phase_q)
                PH_DATA: begin
                    if (seg_end) begin
                        phase_q <= PH_CRC_LO;
                        final_q <= iu_last;
                    end
                end
                PH_CRC_LO: begin
                    if (adv) begin
                        phase_q   <= PH_CRC_HI;
                        miss_lo_q <= (word_in != crc_out[HALF-1:0]);
                    end
                end
                default: begin
                    if (hi_done) begin
                        phase_q <= PH_DATA;
                        if (final_q) active_q <= 1'b0;
                        if (check_q) begin
                            if (miss_lo_q || (word_in != crc_out[CRC_W-1:HALF]))
                                crc_error <= 1'b1;
                            else
                                crc_ok <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/iucrc_checker.sv
module iucrc_checker (
    input logic clk,
    input logic rst,
    input logic crc_valid,
    input logic crc_error,
    input logic crc_ok
);
    // R10: the three result indications never overlap
    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({crc_valid, crc_error, crc_ok}));

    // R10: mismatch report is a single-cycle pulse
    assert_error_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        crc_error |=> !crc_error);

    // R10: match report is a single-cycle pulse
    assert_ok_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        crc_ok |=> !crc_ok);

    // R3: a generated CRC occupies two consecutive cycles
    assert_pair_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(crc_valid) |=> crc_valid);

    // R3: and no more than two
    assert_pair_end_R3: assert property (@(posedge clk) disable iff (rst)
        (crc_valid && $past(crc_valid)) |=> !crc_valid);
endmodule

bind iucrc_unit iucrc_checker u_iucrc_checker (
    .clk       (clk),
    .rst       (rst),
    .crc_valid (crc_valid),
    .crc_error (crc_error),
    .crc_ok    (crc_ok)
);

// File: tb/iucrc_unit_tb.sv
module iucrc_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        check_mode = 1'b0;
    logic        iu_start = 1'b0;
    logic [15:0] crc_interval = '0;
    logic        word_valid = 1'b0;
    logic [15:0] word_in = '0;
    logic        iu_last = 1'b0;
    logic        crc_valid;
    logic [15:0] crc_word;
    logic        crc_error;
    logic        crc_ok;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iucrc_unit u_dut (
        .clk(clk), .rst(rst), .check_mode(check_mode), .iu_start(iu_start),
        .crc_interval(crc_interval), .word_valid(word_valid), .word_in(word_in),
        .iu_last(iu_last), .crc_valid(crc_valid), .crc_word(crc_word),
        .crc_error(crc_error), .crc_ok(crc_ok)
    );

    // kind (0: zeros, 1: ones, 2: ascending bytes), first word, second word
    localparam logic [47:0] VECS [3] = '{
        {16'd0, 16'h55AD, 16'h190A},
        {16'd1, 16'hAB0B, 16'hFF6C},
        {16'd2, 16'h7E8A, 16'h9126}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Serial reference: bytes low half first, bits LSB first, reflected polynomial.
    function automatic logic [31:0] ref_crc(input logic [15:0] ws [16], input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < 2; b++) begin
                logic [7:0] by = (b == 0) ? ws[k][7:0] : ws[k][15:8];
                for (int i = 0; i < 8; i++) begin
                    logic fb = c[0] ^ by[i];
                    c = c >> 1;
                    if (fb) c = c ^ 32'hEDB88320;
                end
            end
        end
        return ~c;
    endfunction

    // Called at a negedge; returns at the next negedge after the word is taken.
    task automatic drive(input logic [15:0] w, input logic st, input logic last);
        word_valid = 1'b1; word_in = w; iu_start = st; iu_last = last;
        @(negedge clk);
        word_valid = 1'b0; iu_start = 1'b0; iu_last = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] ws [16];
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 crc_valid", {31'd0, crc_valid}, 32'd0);
        check("R1 crc_error", {31'd0, crc_error}, 32'd0);
        check("R1 crc_ok",    {31'd0, crc_ok},    32'd0);

        // R2/R3/R5: published patterns, interval 0, generate mode
        for (int v = 0; v < 3; v++) begin
            check_mode = 1'b0; crc_interval = 16'd0;
            for (int k = 0; k < 16; k++) begin
                logic [15:0] w;
                case (VECS[v][47:32])
                    16'd0:   w = 16'h0000;
                    16'd1:   w = 16'hFFFF;
                    default: w = {8'(2*k+1), 8'(2*k)};
                endcase
                if (k < 15) check("R5 no early crc", {31'd0, crc_valid}, 32'd0);
                drive(w, k == 0, k == 15);
            end
            check("R3 first valid", {31'd0, crc_valid}, 32'd1);
            check("R2 first word", {16'd0, crc_word}, {16'd0, VECS[v][31:16]});
            @(negedge clk);
            check("R3 second valid", {31'd0, crc_valid}, 32'd1);
            check("R2 second word", {16'd0, crc_word}, {16'd0, VECS[v][15:0]});
            @(negedge clk);
            check("R3 pair ends", {31'd0, crc_valid}, 32'd0);
        end

        // R4: interval of 8 bytes, two segments of four words each
        crc_interval = 16'd8;
        for (int k = 0; k < 16; k++) ws[k] = 16'h1234 + 16'(k * 16'h0F31);
        for (int s = 0; s < 2; s++) begin
            logic [15:0] seg [16];
            for (int k = 0; k < 16; k++) seg[k] = '0;
            for (int k = 0; k < 4; k++) begin
                seg[k] = ws[4*s+k];
                drive(ws[4*s+k], s == 0 && k == 0, s == 1 && k == 3);
            end
            e = ref_crc(seg, 4);
            check("R4 seg valid", {31'd0, crc_valid}, 32'd1);
            check("R4 seg low", {16'd0, crc_word}, {16'd0, e[15:0]});
            @(negedge clk);
            check("R4 seg high", {16'd0, crc_word}, {16'd0, e[31:16]});
            @(negedge clk);
        end

        // R9: idle words after the unit closed produce nothing
        drive(16'hBEEF, 1'b0, 1'b1);
        check("R9 idle no crc", {31'd0, crc_valid}, 32'd0);
        @(negedge clk);
        check("R9 idle no crc later", {31'd0, crc_valid}, 32'd0);

        // R7: words during CRC emission ignored, interval 4 bytes
        crc_interval = 16'd4;
        begin
            logic [15:0] seg [16];
            for (int k = 0; k < 16; k++) seg[k] = '0;
            drive(16'hA001, 1'b1, 1'b0);
            drive(16'hA002, 1'b0, 1'b0);
            drive(16'hDEAD, 1'b0, 1'b0);   // during first CRC word
            drive(16'hDEAD, 1'b0, 1'b0);   // during second CRC word
            seg[0] = 16'hA003; seg[1] = 16'hA004;
            drive(16'hA003, 1'b0, 1'b0);
            drive(16'hA004, 1'b0, 1'b1);
            e = ref_crc(seg, 2);
            check("R7 next seg low", {16'd0, crc_word}, {16'd0, e[15:0]});
            @(negedge clk);
            check("R7 next seg high", {16'd0, crc_word}, {16'd0, e[31:16]});
            @(negedge clk);
        end

        // R8: restart mid-segment
        crc_interval = 16'd0;
        begin
            logic [15:0] seg [16];
            for (int k = 0; k < 16; k++) seg[k] = '0;
            drive(16'h1111, 1'b1, 1'b0);
            drive(16'h2222, 1'b0, 1'b0);
            seg[0] = 16'h3333; seg[1] = 16'h4444;
            drive(16'h3333, 1'b1, 1'b0);
            drive(16'h4444, 1'b0, 1'b1);
            e = ref_crc(seg, 2);
            check("R8 restart low", {16'd0, crc_word}, {16'd0, e[15:0]});
            @(negedge clk);
            check("R8 restart high", {16'd0, crc_word}, {16'd0, e[31:16]});
            @(negedge clk);
        end

        // R6/R10: check mode, good then corrupted CRC
        for (int t = 0; t < 2; t++) begin
            logic [15:0] seg [16];
            for (int k = 0; k < 16; k++) seg[k] = '0;
            check_mode = 1'b1;
            for (int k = 0; k < 3; k++) begin
                seg[k] = 16'h5A00 + 16'(k);
                drive(seg[k], k == 0, k == 2);
            end
            e = ref_crc(seg, 3);
            check("R6 no valid in check mode", {31'd0, crc_valid}, 32'd0);
            drive(e[15:0], 1'b0, 1'b0);
            check("R6 no early verdict", {30'd0, crc_error, crc_ok}, 32'd0);
            drive(e[31:16] ^ (t == 1 ? 16'h0100 : 16'h0000), 1'b0, 1'b0);
            check("R6 crc_error", {31'd0, crc_error}, {31'd0, t == 1});
            check("R6 crc_ok",    {31'd0, crc_ok},    {31'd0, t == 0});
            @(negedge clk);
            check("R10 pulse ends", {30'd0, crc_error, crc_ok}, 32'd0);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule